// File: doc/BRIEF.md
# Tag-Broadcast Wakeup Issue Queue

This block holds renamed instructions until their source operands exist. Each slot stores an opcode, the tag the instruction will produce, and two source fields, each with a ready flag. A source that is not yet ready holds the tag of its producer. A ready source holds the physical register id where the value lives. When a producer completes, its tag and newly assigned physical register id are broadcast. Every waiting source whose tag matches is rewritten in place with the physical id and marked ready.

A slot whose two sources are both ready is eligible. Each cycle the oldest eligible slot is issued. It presents its physical source ids for the register read and is freed at the next clock edge. A squashed instruction that already has its operands can be put back as a new entry with both sources flagged ready.

Top module: `wakeup_iq`

## Requirements
- R1: After reset the queue is empty: `iss_valid` is 0 and `ins_ready` is 1.
- R2: While `ins_ready` is 1, an insert with `ins_valid` high stores one entry at the clock edge. A source flag of 1 means its field holds a physical id in the low `PHYS_W` bits. A flag of 0 means the field holds a tag in the low `TAG_W` bits.
- R3: A broadcast (`wb_valid` high) whose `wb_tag` equals a stored not-ready source field replaces that field with `wb_phys` and sets its flag. This is visible from the next cycle.
- R4: A source that is already ready is never compared. Its physical id is kept even when it equals the broadcast tag.
- R5: An entry is eligible to issue only when both of its source flags are set. `iss_valid` is 0 while no stored entry is eligible.
- R6: A not-ready source whose tag matches a broadcast in the same cycle it is inserted is stored as ready, holding `wb_phys`.
- R7: At most one entry issues per cycle. The issue outputs are driven from stored state in the same cycle, and the chosen entry is the oldest eligible one by insertion order. Its slot is free after the next clock edge.
- R8: When all `DEPTH` slots are occupied, `ins_ready` is 0 and an insert is ignored. A slot freed by an issue in the same cycle is not reusable until the following cycle.
- R9: An entry inserted with both flags set (a squashed instruction put back) is eligible in the cycle after insertion. It issues then if it is the oldest eligible entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request |
| ins_op | input | OP_W | Opcode of the inserted instruction |
| ins_dst_tag | input | TAG_W | Destination tag of the inserted instruction |
| ins_src0 | input | SRC_W | Source 0 field: tag or physical id |
| ins_rdy0 | input | 1 | Source 0 holds a physical id |
| ins_src1 | input | SRC_W | Source 1 field: tag or physical id |
| ins_rdy1 | input | 1 | Source 1 holds a physical id |
| ins_ready | output | 1 | A slot is free; an insert is taken this cycle |
| wb_valid | input | 1 | Completion broadcast valid |
| wb_tag | input | TAG_W | Completing tag |
| wb_phys | input | PHYS_W | Physical register id assigned to that tag |
| iss_valid | output | 1 | An entry is issued this cycle |
| iss_op | output | OP_W | Opcode of the issued entry |
| iss_dst_tag | output | TAG_W | Destination tag of the issued entry |
| iss_src0 | output | PHYS_W | Physical id of source 0 |
| iss_src1 | output | PHYS_W | Physical id of source 1 |

## Verification
The issue outputs and `ins_ready` depend only on stored state. An insert or a broadcast applied in one cycle therefore shows at the ports exactly one clock edge later, and an issue frees its slot at the edge that ends its cycle. The bench drives inputs on the falling edge and samples outputs 1 ns later, before the rising edge. It compares them with a model that it updates only after that rising edge, so every expectation is aligned to the one-edge delay. The directed cases place the same-cycle insert/broadcast match, a ready source whose id equals a broadcast tag, the full queue and the reinserted entry so that the check in the following cycle observes each effect.

// File: rtl/wiq_pkg.sv
package wiq_pkg;
  parameter int OP_W   = 6;
  parameter int TAG_W  = 6;
  parameter int PHYS_W = 5;
  localparam int SRC_W = (TAG_W > PHYS_W) ? TAG_W : PHYS_W;

  typedef logic [OP_W-1:0]   op_t;
  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [PHYS_W-1:0] phys_t;
  typedef logic [SRC_W-1:0]  src_t;

  typedef struct packed {
    logic vld;
    op_t  op;
    tag_t dst;
    src_t s0;
    logic r0;
    src_t s1;
    logic r1;
  } entry_t;

  // A waiting source hits when a broadcast carries its tag.
  function automatic logic wake_hit(input logic rdy, input src_t src,
                                    input logic bc_v, input tag_t bc_tag);
    return bc_v && !rdy && (src == src_t'(bc_tag));
  endfunction

  function automatic src_t phys_to_src(input phys_t p);
    return src_t'(p);
  endfunction

  function automatic phys_t src_to_phys(input src_t s);
    return phys_t'(s);
  endfunction

  // Source field after a possible wakeup.
  function automatic src_t wake_field(input logic rdy, input src_t src,
                                      input logic bc_v, input tag_t bc_tag,
                                      input phys_t bc_phys);
    return wake_hit(rdy, src, bc_v, bc_tag) ? phys_to_src(bc_phys) : src;
  endfunction
endpackage

// File: rtl/wiq_slot.sv
module wiq_slot
  import wiq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  entry_t wr_entry,
  input  logic   clr,
  input  logic   bc_valid,
  input  tag_t   bc_tag,
  input  phys_t  bc_phys,
  output entry_t cur,
  output logic   wake0,
  output logic   wake1
);
  entry_t st;

  assign wake0 = st.vld && wake_hit(st.r0, st.s0, bc_valid, bc_tag);
  assign wake1 = st.vld && wake_hit(st.r1, st.s1, bc_valid, bc_tag);
  assign cur   = st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= '0;
    end else if (wr_en) begin
      st <= wr_entry;
    end else begin
      if (clr) st.vld <= 1'b0;
      if (wake0) begin
        st.s0 <= phys_to_src(bc_phys);
        st.r0 <= 1'b1;
      end
      if (wake1) begin
        st.s1 <= phys_to_src(bc_phys);
        st.r1 <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wiq_alloc.sv
module wiq_alloc #(
  parameter int DEPTH = 8
) (
  input  logic [DEPTH-1:0] vld,
  output logic             full,
  output logic [DEPTH-1:0] free_oh
);
  assign full = &vld;

  // Lowest-numbered free slot.
  always_comb begin
    logic found;
    found   = 1'b0;
    free_oh = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld[i] && !found) begin
        free_oh[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wiq_age_sel.sv
module wiq_age_sel #(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] ins_oh,
  input  logic [DEPTH-1:0] vld,
  input  logic [DEPTH-1:0] req,
  output logic [DEPTH-1:0] gnt
);
  // older[j][i] set: slot j was inserted before slot i.
  logic [DEPTH-1:0] older [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < DEPTH; r++) older[r] <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) begin
        if (ins_oh[k]) begin
          older[k] <= '0;
          for (int j = 0; j < DEPTH; j++)
            if (j != k) older[j][k] <= vld[j];
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < DEPTH; j++)
        blocked = blocked | (req[j] & older[j][i]);
      gnt[i] = req[i] & ~blocked;
    end
  end
endmodule

// File: rtl/wakeup_iq.sv
module wakeup_iq
  import wiq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [OP_W-1:0]   ins_op,
  input  logic [TAG_W-1:0]  ins_dst_tag,
  input  logic [SRC_W-1:0]  ins_src0,
  input  logic              ins_rdy0,
  input  logic [SRC_W-1:0]  ins_src1,
  input  logic              ins_rdy1,
  output logic              ins_ready,
  input  logic              wb_valid,
  input  logic [TAG_W-1:0]  wb_tag,
  input  logic [PHYS_W-1:0] wb_phys,
  output logic              iss_valid,
  output logic [OP_W-1:0]   iss_op,
  output logic [TAG_W-1:0]  iss_dst_tag,
  output logic [PHYS_W-1:0] iss_src0,
  output logic [PHYS_W-1:0] iss_src1
);
  entry_t           ent [DEPTH];
  entry_t           ins_ent;
  entry_t           sel;
  logic [DEPTH-1:0] vld_vec, r0_vec, r1_vec, elig_vec;
  logic [DEPTH-1:0] wake0_vec, wake1_vec, alloc_oh, ins_oh, gnt;
  logic             full, ins_fire;

  assign ins_ready = !full;
  assign ins_fire  = ins_valid && !full;
  assign ins_oh    = ins_fire ? alloc_oh : '0;

  // Same-cycle wakeup of the entry being written (R6).
  always_comb begin
    ins_ent     = '0;
    ins_ent.vld = 1'b1;
    ins_ent.op  = ins_op;
    ins_ent.dst = ins_dst_tag;
    ins_ent.s0  = wake_field(ins_rdy0, ins_src0, wb_valid, wb_tag, wb_phys);
    ins_ent.r0  = ins_rdy0 | wake_hit(ins_rdy0, ins_src0, wb_valid, wb_tag);
    ins_ent.s1  = wake_field(ins_rdy1, ins_src1, wb_valid, wb_tag, wb_phys);
    ins_ent.r1  = ins_rdy1 | wake_hit(ins_rdy1, ins_src1, wb_valid, wb_tag);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    wiq_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ins_oh[g]),
      .wr_entry (ins_ent),
      .clr      (gnt[g]),
      .bc_valid (wb_valid),
      .bc_tag   (wb_tag),
      .bc_phys  (wb_phys),
      .cur      (ent[g]),
      .wake0    (wake0_vec[g]),
      .wake1    (wake1_vec[g])
    );
    assign vld_vec[g]  = ent[g].vld;
    assign r0_vec[g]   = ent[g].r0;
    assign r1_vec[g]   = ent[g].r1;
    assign elig_vec[g] = ent[g].vld & ent[g].r0 & ent[g].r1;
  end

  wiq_alloc #(.DEPTH(DEPTH)) u_alloc (
    .vld     (vld_vec),
    .full    (full),
    .free_oh (alloc_oh)
  );

  wiq_age_sel #(.DEPTH(DEPTH)) u_age (
    .clk    (clk),
    .rst_n  (rst_n),
    .ins_oh (ins_oh),
    .vld    (vld_vec),
    .req    (elig_vec),
    .gnt    (gnt)
  );

  always_comb begin
    sel = '0;
    for (int i = 0; i < DEPTH; i++)
      if (gnt[i]) sel = entry_t'(sel | ent[i]);
  end

  assign iss_valid   = |gnt;
  assign iss_op      = sel.op;
  assign iss_dst_tag = sel.dst;
  assign iss_src0    = src_to_phys(sel.s0);
  assign iss_src1    = src_to_phys(sel.s1);
endmodule

// File: rtl/wiq_checker.sv
module wiq_checker #(
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DEPTH-1:0] vld_vec,
  input logic [DEPTH-1:0] r0_vec,
  input logic [DEPTH-1:0] r1_vec,
  input logic [DEPTH-1:0] wake0_vec,
  input logic [DEPTH-1:0] wake1_vec,
  input logic [DEPTH-1:0] gnt,
  input logic             ins_fire,
  input logic             ins_ready,
  input logic             iss_valid
);
  p_one_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  p_issue_eligible_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~(vld_vec & r0_vec & r1_vec)) == '0);

  p_full_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (&vld_vec) |-> !ins_ready);

  p_occupancy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(vld_vec) + $past(32'(iss_valid)))
             == ($past($countones(vld_vec)) + $past(32'(ins_fire))));

  p_wake0_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wake0_vec != '0) |=> ((r0_vec & $past(wake0_vec)) == $past(wake0_vec)));

  p_wake1_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wake1_vec != '0) |=> ((r1_vec & $past(wake1_vec)) == $past(wake1_vec)));

  p_ready_no_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((wake0_vec & r0_vec) == '0) && ((wake1_vec & r1_vec) == '0));
endmodule

bind wakeup_iq wiq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .vld_vec   (vld_vec),
  .r0_vec    (r0_vec),
  .r1_vec    (r1_vec),
  .wake0_vec (wake0_vec),
  .wake1_vec (wake1_vec),
  .gnt       (gnt),
  .ins_fire  (ins_fire),
  .ins_ready (ins_ready),
  .iss_valid (iss_valid)
);

// File: tb/tb_wakeup_iq.sv
module tb_wakeup_iq;
  import wiq_pkg::*;
  localparam int DEPTH = 8;

  logic  clk = 1'b0;
  logic  rst_n = 1'b0;
  logic  ins_valid = 1'b0, ins_rdy0 = 1'b0, ins_rdy1 = 1'b0, ins_ready;
  op_t   ins_op = '0;
  tag_t  ins_dst_tag = '0;
  src_t  ins_src0 = '0, ins_src1 = '0;
  logic  wb_valid = 1'b0;
  tag_t  wb_tag = '0;
  phys_t wb_phys = '0;
  logic  iss_valid;
  op_t   iss_op;
  tag_t  iss_dst_tag;
  phys_t iss_src0, iss_src1;

  always #5 clk = ~clk;

  wakeup_iq #(.DEPTH(DEPTH)) dut (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // Reference model: unordered entries with an insertion sequence number.
  logic m_vld [DEPTH];
  int   m_seq [DEPTH];
  op_t  m_op  [DEPTH];
  tag_t m_dst [DEPTH];
  src_t m_s0  [DEPTH], m_s1 [DEPTH];
  logic m_r0  [DEPTH], m_r1 [DEPTH];
  int   seq_ctr = 0;

  function automatic int m_count();
    int c = 0;
    for (int i = 0; i < DEPTH; i++) if (m_vld[i]) c++;
    return c;
  endfunction

  function automatic int m_oldest_ready();
    int best = -1;
    for (int i = 0; i < DEPTH; i++)
      if (m_vld[i] && m_r0[i] && m_r1[i] && (best < 0 || m_seq[i] < m_seq[best]))
        best = i;
    return best;
  endfunction

  function automatic logic hits(logic rdy, src_t s);
    return wb_valid && !rdy && (s[TAG_W-1:0] == wb_tag) && (s >> TAG_W) == 0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) begin
      m_vld[i] = 1'b0; m_r0[i] = 1'b0; m_r1[i] = 1'b0;
    end
  endtask

  task automatic set_idle();
    ins_valid = 1'b0; wb_valid = 1'b0;
  endtask

  task automatic set_ins(input op_t op, input tag_t d, input src_t s0, input logic r0,
                         input src_t s1, input logic r1);
    ins_valid = 1'b1; ins_op = op; ins_dst_tag = d;
    ins_src0 = s0; ins_rdy0 = r0; ins_src1 = s1; ins_rdy1 = r1;
  endtask

  task automatic set_wb(input tag_t t, input phys_t p);
    wb_valid = 1'b1; wb_tag = t; wb_phys = p;
  endtask

  // Inputs already set (at negedge). Check outputs, then advance model after posedge.
  task automatic run_cycle(input string lbl);
    int    o, cnt, fr;
    logic [63:0] act, exp;
    #1;
    o   = m_oldest_ready();
    cnt = m_count();
    check(iss_valid == (o >= 0), lbl, 64'(iss_valid), 64'(o >= 0));
    if (o >= 0) begin
      act = {iss_op, iss_dst_tag, iss_src0, iss_src1};
      exp = {m_op[o], m_dst[o], phys_t'(m_s0[o]), phys_t'(m_s1[o])};
      check(act == exp, lbl, act, exp);
    end
    check(ins_ready == (cnt < DEPTH), (cnt == DEPTH) ? "R8" : lbl,
          64'(ins_ready), 64'(cnt < DEPTH));
    @(posedge clk);
    for (int i = 0; i < DEPTH; i++) if (m_vld[i]) begin
      if (hits(m_r0[i], m_s0[i])) begin m_s0[i] = src_t'(wb_phys); m_r0[i] = 1'b1; end
      if (hits(m_r1[i], m_s1[i])) begin m_s1[i] = src_t'(wb_phys); m_r1[i] = 1'b1; end
    end
    if (o >= 0) m_vld[o] = 1'b0;
    if (ins_valid && cnt < DEPTH) begin
      fr = -1;
      for (int i = 0; i < DEPTH; i++) if (!m_vld[i] && fr < 0 && i != o) fr = i;
      if (fr < 0) fr = o;
      m_vld[fr] = 1'b1; m_seq[fr] = seq_ctr++; m_op[fr] = ins_op; m_dst[fr] = ins_dst_tag;
      m_s0[fr] = hits(ins_rdy0, ins_src0) ? src_t'(wb_phys) : ins_src0;
      m_r0[fr] = ins_rdy0 | hits(ins_rdy0, ins_src0);
      m_s1[fr] = hits(ins_rdy1, ins_src1) ? src_t'(wb_phys) : ins_src1;
      m_r1[fr] = ins_rdy1 | hits(ins_rdy1, ins_src1);
    end
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    int ins_pct, wb_pct;
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    #1;
    check(iss_valid == 1'b0, "R1", 64'(iss_valid), 64'd0);
    check(ins_ready == 1'b1, "R1", 64'(ins_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    set_idle(); run_cycle("R1");

    // R6: insert and matching broadcast in the same cycle
    set_ins(6'd1, 6'd1, src_t'(5), 1'b0, src_t'(2), 1'b1);
    set_wb(6'd5, 5'd9);
    run_cycle("R2");
    set_idle();
    #1;
    check(iss_valid && iss_src0 == 5'd9, "R6", 64'(iss_src0), 64'd9);
    run_cycle("R6");

    // R4: ready source equal to broadcast tag is untouched
    set_ins(6'd2, 6'd2, src_t'(3), 1'b1, src_t'(7), 1'b0);
    run_cycle("R2");
    set_idle(); set_wb(6'd3, 5'd20); run_cycle("R5");
    set_idle(); set_wb(6'd7, 5'd11); run_cycle("R4");
    set_idle();
    #1;
    check({iss_src0, iss_src1} == {5'd3, 5'd11}, "R4", 64'({iss_src0, iss_src1}), 64'({5'd3, 5'd11}));
    run_cycle("R3");

    // R8: fill the queue with waiting entries, then try one more
    for (int k = 0; k < DEPTH; k++) begin
      set_ins(op_t'(16 + k), tag_t'(k), src_t'(10), 1'b0, src_t'(1), 1'b1);
      run_cycle("R5");
    end
    set_ins(6'd63, 6'd63, src_t'(4), 1'b1, src_t'(4), 1'b1);
    #1;
    check(ins_ready == 1'b0, "R8", 64'(ins_ready), 64'd0);
    run_cycle("R8");
    set_idle(); set_wb(6'd10, 5'd4); run_cycle("R5");
    set_idle();
    for (int k = 0; k < DEPTH; k++) begin
      #1;
      check(iss_op == op_t'(16 + k), "R7", 64'(iss_op), 64'(16 + k));
      run_cycle("R7");
    end
    run_cycle("R8");

    // R9: reinserted squashed entry passes an older waiting one
    set_ins(6'd40, 6'd40, src_t'(12), 1'b0, src_t'(0), 1'b1); run_cycle("R2");
    set_ins(6'd41, 6'd41, src_t'(6), 1'b1, src_t'(8), 1'b1);  run_cycle("R9");
    set_idle();
    #1;
    check(iss_valid && iss_op == 6'd41, "R9", 64'(iss_op), 64'd41);
    run_cycle("R9");
    set_wb(6'd12, 5'd13); run_cycle("R3");
    set_idle(); run_cycle("R7");

    // Constrained random phases
    for (int ph = 0; ph < 20; ph++) begin
      ins_pct = 30 + 10 * (ph % 7);
      wb_pct  = 20 + 15 * (ph % 5);
      for (int c = 0; c < 150; c++) begin
        ins_valid = ($urandom_range(99) < ins_pct);
        ins_op = op_t'($urandom); ins_dst_tag = tag_t'($urandom_range(15));
        ins_rdy0 = $urandom_range(1); ins_rdy1 = $urandom_range(1);
        ins_src0 = ins_rdy0 ? src_t'($urandom_range(31)) : src_t'($urandom_range(15));
        ins_src1 = ins_rdy1 ? src_t'($urandom_range(31)) : src_t'($urandom_range(15));
        wb_valid = ($urandom_range(99) < wb_pct);
        wb_tag = tag_t'($urandom_range(15)); wb_phys = phys_t'($urandom);
        run_cycle("R3 R5 R7");
      end
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule